// File: doc/BRIEF.md
# PCM TDM Timeslot Channel Mapper

This block sits on a serial PCM highway and links it to four parallel 8-bit sample channels. The block's clock is the highway bit clock. A one-clock frame-sync pulse on `fsync` starts each frame, and the spacing between pulses sets the frame length. Each frame carries one companded sample per channel in each direction, and every timeslot is 8 bit clocks wide.

Each channel has its own transmit slot number, receive slot number and power-up bit for each direction. On the transmit side, a powered channel shifts the sample it latched at frame start onto `sdo`, most significant bit first, during its slot. `sdo_oe` marks the clocks the block owns. On the receive side, a powered channel collects the 8 bits of its slot from `sdi` and presents them as a parallel word with a one-clock valid strobe. A global delay bit moves all slot data one clock later relative to the frame sync. If two powered transmit channels claim the same slot, the lower-numbered channel drives it and a clash flag is raised.

Top module: `pcm_slot_mapper`

## Requirements
- R1: After reset and before the first frame sync, `sdo_oe`, `sdo`, `tx_clash` and every `rx_valid` bit are low, and every `rx_data` word is zero.
- R2: With `delay_mode` low, the clock in which `fsync` is high is frame bit 0. Slot s occupies frame bits 8s to 8s+7, and the sample's bit 7 is sent first.
- R3: With `delay_mode` high, all slot data comes one clock later. Slot 0 bit 7 falls in the clock after `fsync`, and the final bit of the frame's last slot falls in the clock of the next `fsync`.
- R4: A channel drives `sdo` only while its transmit power bit (`tx_pwr[ch]`) is set and the current slot equals its transmit slot number. `sdo_oe` is high exactly in the clocks that some channel drives, and `sdo` is 0 whenever `sdo_oe` is low.
- R5: A channel's transmit word is taken from `tx_data` in the `fsync` clock. In no-delay mode, slot 0 bits in that same clock also come from the value present then. Later changes to `tx_data` have no effect until the next `fsync`.
- R6: A powered receive channel shifts `sdi` in, most significant bit first, during the 8 clocks of its receive slot. After the edge that samples the eighth bit, `rx_data[ch]` holds the word and `rx_valid[ch]` is high for exactly one clock. At all other times `rx_data[ch]` is unchanged.
- R7: With `rx_pwr[ch]` low, channel ch never raises `rx_valid[ch]` and its `rx_data[ch]` stays unchanged.
- R8: When two or more powered transmit channels claim the current slot, the lowest-numbered one supplies `sdo`, and `tx_clash` is high in exactly those clocks.
- R9: Frame position restarts at every `fsync`, whatever the spacing. Frames of any length work, and each channel's transmit and receive slot numbers are independent of each other and of other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsync | input | 1 | One-clock frame start pulse |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data, 0 when not driven |
| sdo_oe | output | 1 | High in clocks where the block drives `sdo` |
| delay_mode | input | 1 | 1: slot data begins one clock after `fsync` |
| tx_pwr | input | NCH | Per-channel transmit power-up |
| rx_pwr | input | NCH | Per-channel receive power-up |
| tx_slot_cfg | input | NCH*8 | Transmit slot number, channel ch at bits [8ch+7:8ch] |
| rx_slot_cfg | input | NCH*8 | Receive slot number, channel ch at bits [8ch+7:8ch] |
| tx_data | input | NCH*8 | Transmit samples, channel ch at bits [8ch+7:8ch] |
| rx_data | output | NCH*8 | Received samples, channel ch at bits [8ch+7:8ch] |
| rx_valid | output | NCH | One-clock strobe per channel when a new word lands |
| tx_clash | output | 1 | Two or more powered transmit channels share the current slot |

## Verification
The mapper runs back-to-back frames with random serial input and several slot maps. These include scattered distinct slots in both timing modes, partly powered transmit and receive sets, and shared transmit slots. Comparing the two timing modes on the same map separates a correct one-clock data shift from an off-by-one at the frame boundary. The shared-slot maps show whether priority favours the lowest channel. Further frames churn `tx_data` on every clock, which catches a sample taken at the wrong moment. Frames of 32, 40 and 96 clocks check the restart on `fsync`. A loopback pass feeds `sdo` into `sdi`, so transmitted words must come back unchanged on the receive ports.

// File: rtl/pcm_map_pkg.sv
package pcm_map_pkg;
  localparam int SMP_W  = 8;                 // companded sample width
  localparam int BIT_W  = $clog2(SMP_W);     // bit index within a slot
  localparam int SLOT_W = 8;                 // slot number width

  typedef struct packed {
    logic              act;   // highway position is meaningful
    logic [SLOT_W-1:0] slot;  // current timeslot
    logic [BIT_W-1:0]  bidx;  // bit within slot, 0 = first (MSB)
  } hwy_pos_t;
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_map_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fsync,
  input  logic     delay_mode,
  output hwy_pos_t cur,
  output logic     use_live,
  output logic     frame_start
);
  localparam int POS_W = SLOT_W + BIT_W;

  logic [POS_W-1:0] pos_q, pos_d, data_pos;
  logic             sync_q, sync_d;

  always_comb begin
    pos_d  = fsync ? '0 : pos_q + 1'b1;
    sync_d = sync_q | fsync;
    if (delay_mode) begin
      // one clock late: the data bit of this clock is the previous position
      data_pos = pos_q;
      cur.act  = sync_q;
    end else begin
      data_pos = pos_d;
      cur.act  = sync_q | fsync;
    end
    cur.slot    = data_pos[POS_W-1:BIT_W];
    cur.bidx    = data_pos[BIT_W-1:0];
    use_live    = fsync & ~delay_mode;
    frame_start = fsync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  hwy_pos_t          cur,
  input  logic              frame_start,
  input  logic              use_live,
  input  logic              pwr,
  input  logic [SLOT_W-1:0] slot_cfg,
  input  logic [SMP_W-1:0]  smp_in,
  output logic              claim,
  output logic              bit_val
);
  localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(SMP_W - 1);

  logic [SMP_W-1:0] held_q, held_d, eff;

  always_comb begin
    held_d  = frame_start ? smp_in : held_q;
    eff     = use_live ? smp_in : held_q;
    claim   = pwr & cur.act & (cur.slot == slot_cfg);
    bit_val = eff[TOP_IDX - cur.bidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end
endmodule

// File: rtl/pcm_tx_arbiter.sv
module pcm_tx_arbiter #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] claim,
  input  logic [NCH-1:0] bits,
  output logic           drive,
  output logic           sdo_bit,
  output logic           clash
);
  localparam int CW = $clog2(NCH + 1);

  logic          sel;
  logic [CW-1:0] cnt;

  always_comb begin
    drive = 1'b0;
    sel   = 1'b0;
    cnt   = '0;
    // descending scan: the last hit written is the lowest channel
    for (int i = NCH - 1; i >= 0; i--) begin
      if (claim[i]) begin
        drive = 1'b1;
        sel   = bits[i];
      end
    end
    for (int i = 0; i < NCH; i++) cnt = cnt + CW'(claim[i]);
    clash   = (cnt > CW'(1));
    sdo_bit = drive & sel;
  end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  hwy_pos_t          cur,
  input  logic              pwr,
  input  logic [SLOT_W-1:0] slot_cfg,
  input  logic              sdi,
  output logic [SMP_W-1:0]  smp_out,
  output logic              vld
);
  localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(SMP_W - 1);

  logic [SMP_W-1:0] sh_q, sh_d, out_q, out_d, word;
  logic             vld_q, vld_d, take, last;

  always_comb begin
    take  = pwr & cur.act & (cur.slot == slot_cfg);
    last  = take & (cur.bidx == TOP_IDX);
    word  = {sh_q[SMP_W-2:0], sdi};
    sh_d  = take ? word : sh_q;
    out_d = last ? word : out_q;
    vld_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign smp_out = out_q;
  assign vld     = vld_q;
endmodule

// File: rtl/pcm_slot_mapper.sv
module pcm_slot_mapper
  import pcm_map_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic                  delay_mode,
  input  logic [NCH-1:0]        tx_pwr,
  input  logic [NCH-1:0]        rx_pwr,
  input  logic [NCH*SLOT_W-1:0] tx_slot_cfg,
  input  logic [NCH*SLOT_W-1:0] rx_slot_cfg,
  input  logic [NCH*SMP_W-1:0]  tx_data,
  output logic [NCH*SMP_W-1:0]  rx_data,
  output logic [NCH-1:0]        rx_valid,
  output logic                  tx_clash
);
  logic     rst_meta_q, rst_sync_q;
  hwy_pos_t cur;
  logic     use_live, frame_start;
  logic [NCH-1:0] claim, bits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pcm_frame_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .fsync       (fsync),
    .delay_mode  (delay_mode),
    .cur         (cur),
    .use_live    (use_live),
    .frame_start (frame_start)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pcm_tx_lane u_tx (
      .clk         (clk),
      .rst_n       (rst_sync_q),
      .cur         (cur),
      .frame_start (frame_start),
      .use_live    (use_live),
      .pwr         (tx_pwr[ch]),
      .slot_cfg    (tx_slot_cfg[ch*SLOT_W +: SLOT_W]),
      .smp_in      (tx_data[ch*SMP_W +: SMP_W]),
      .claim       (claim[ch]),
      .bit_val     (bits[ch])
    );

    pcm_rx_lane u_rx (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .cur      (cur),
      .pwr      (rx_pwr[ch]),
      .slot_cfg (rx_slot_cfg[ch*SLOT_W +: SLOT_W]),
      .sdi      (sdi),
      .smp_out  (rx_data[ch*SMP_W +: SMP_W]),
      .vld      (rx_valid[ch])
    );
  end

  pcm_tx_arbiter #(.NCH(NCH)) u_arb (
    .claim   (claim),
    .bits    (bits),
    .drive   (sdo_oe),
    .sdo_bit (sdo),
    .clash   (tx_clash)
  );
endmodule

// File: rtl/pcm_slot_mapper_chk.sv
module pcm_slot_mapper_chk #(
  parameter int NCH   = 4,
  parameter int SMP_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fsync,
  input logic                 sdo_oe,
  input logic                 tx_clash,
  input logic [NCH-1:0]       tx_pwr,
  input logic [NCH-1:0]       rx_pwr,
  input logic [NCH*SMP_W-1:0] rx_data,
  input logic [NCH-1:0]       rx_valid
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= 1'b0;
    else if (fsync) seen_q <= 1'b1;
  end

  assert_quiet_before_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !fsync) |-> !sdo_oe);

  assert_no_drive_unpowered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pwr == '0) |-> !sdo_oe);

  assert_clash_has_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clash |-> sdo_oe);

  for (genvar i = 0; i < NCH; i++) begin : g_rx
    assert_valid_one_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[i] |=> !rx_valid[i]);

    assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid[i] |-> $stable(rx_data[i*SMP_W +: SMP_W]));

    assert_valid_needs_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[i] |-> $past(rx_pwr[i]));
  end
endmodule

bind pcm_slot_mapper pcm_slot_mapper_chk #(.NCH(NCH), .SMP_W(pcm_map_pkg::SMP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fsync    (fsync),
  .sdo_oe   (sdo_oe),
  .tx_clash (tx_clash),
  .tx_pwr   (tx_pwr),
  .rx_pwr   (rx_pwr),
  .rx_data  (rx_data),
  .rx_valid (rx_valid)
);

// File: tb/pcm_slot_mapper_tb.sv
module pcm_slot_mapper_tb;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic fsync, sdi, sdo, sdo_oe, delay_mode, tx_clash;
  logic [NCH-1:0]   tx_pwr, rx_pwr, rx_valid;
  logic [NCH*8-1:0] tx_slot_cfg, rx_slot_cfg, tx_data, rx_data;

  always #4 clk = ~clk;  // 125 MHz

  pcm_slot_mapper #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .delay_mode(delay_mode), .tx_pwr(tx_pwr), .rx_pwr(rx_pwr),
    .tx_slot_cfg(tx_slot_cfg), .rx_slot_cfg(rx_slot_cfg), .tx_data(tx_data),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_clash(tx_clash)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  int         mpos;
  bit         msync;
  logic [7:0] mheld [NCH];
  logic [7:0] mshift[NCH];
  logic [7:0] mrx   [NCH];
  logic       mvld  [NCH];

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mpos = 0; msync = 0;
    for (int c = 0; c < NCH; c++) begin
      mheld[c] = 0; mshift[c] = 0; mrx[c] = 0; mvld[c] = 0;
    end
  endtask

  // inputs for the cycle are set; compare outputs, then advance the model and clock
  task automatic tick();
    int cp, d, slot, b, owner, n;
    bit act;
    logic [7:0] smp;
    logic e_sdo;
    #1;
    cp = fsync ? 0 : (mpos + 1) % 2048;
    if (delay_mode) begin d = mpos; act = msync; end
    else begin d = cp; act = msync || fsync; end
    slot = d / 8; b = d % 8;
    owner = -1; n = 0;
    for (int c = 0; c < NCH; c++)
      if (tx_pwr[c] && act && (tx_slot_cfg[c*8 +: 8] == slot[7:0])) begin
        n++;
        if (owner < 0) owner = c;
      end
    e_sdo = 1'b0;
    if (owner >= 0) begin
      smp = (fsync && !delay_mode) ? tx_data[owner*8 +: 8] : mheld[owner];
      e_sdo = smp[7 - b];
    end
    cmp("sdo_oe", {31'b0, sdo_oe}, {31'b0, owner >= 0});
    cmp("sdo", {31'b0, sdo}, {31'b0, e_sdo});
    cmp("tx_clash", {31'b0, tx_clash}, {31'b0, n > 1});
    for (int c = 0; c < NCH; c++) begin
      cmp($sformatf("rx_valid[%0d]", c), {31'b0, rx_valid[c]}, {31'b0, mvld[c]});
      cmp($sformatf("rx_data[%0d]", c), {24'b0, rx_data[c*8 +: 8]}, {24'b0, mrx[c]});
    end
    for (int c = 0; c < NCH; c++) begin
      mvld[c] = 1'b0;
      if (rx_pwr[c] && act && (rx_slot_cfg[c*8 +: 8] == slot[7:0])) begin
        mshift[c] = {mshift[c][6:0], sdi};
        if (b == 7) begin mrx[c] = mshift[c]; mvld[c] = 1'b1; end
      end
      if (fsync) mheld[c] = tx_data[c*8 +: 8];
    end
    mpos = cp;
    msync = msync || fsync;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_slots(input logic [31:0] txs, input logic [31:0] rxs);
    tx_slot_cfg = txs; rx_slot_cfg = rxs;
  endtask

  // mode 0: change tx_data mid-frame, 1: every clock, 2: loopback sdo to sdi
  task automatic run_frame(input int len, input int mode);
    for (int k = 0; k < len; k++) begin
      fsync = (k == 0);
      if (mode == 1 || (mode == 0 && k == len / 2)) tx_data = $urandom;
      sdi = $urandom;
      if (mode == 2) begin
        #1;
        if (sdo_oe) sdi = sdo;
      end
      tick();
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fsync = 0; sdi = 0; delay_mode = 0;
    tx_pwr = '1; rx_pwr = '1; tx_data = 32'h5AC3_9E17;
    set_slots(32'h07_05_03_00, 32'h04_06_02_01);
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    cmp("sdo_oe in reset", {31'b0, sdo_oe}, 32'd0);
    cmp("rx_valid in reset", {28'b0, rx_valid}, 32'd0);
    cmp("rx_data in reset", rx_data, 32'd0);
    rst_n = 1;
    repeat (5) tick();

    cur_req = "R2"; delay_mode = 0;
    repeat (3) run_frame(64, 0);

    cur_req = "R3"; delay_mode = 1;
    repeat (3) run_frame(64, 0);

    cur_req = "R4"; delay_mode = 0; tx_pwr = 4'b0101;
    repeat (2) run_frame(64, 0);
    tx_pwr = 4'b0000;
    run_frame(64, 0);

    cur_req = "R7"; tx_pwr = 4'b1111; rx_pwr = 4'b0011;
    repeat (2) run_frame(64, 0);
    rx_pwr = 4'b0000;
    run_frame(64, 0);

    cur_req = "R8"; rx_pwr = 4'b1111;
    set_slots(32'h06_02_02_02, 32'h03_02_01_00);
    repeat (2) run_frame(64, 0);
    delay_mode = 1;
    set_slots(32'h01_01_04_04, 32'h03_02_01_00);
    repeat (2) run_frame(64, 0);

    cur_req = "R5";
    set_slots(32'h07_05_03_00, 32'h04_06_02_01);
    delay_mode = 0;
    repeat (2) run_frame(64, 1);
    delay_mode = 1;
    repeat (2) run_frame(64, 1);

    cur_req = "R9"; delay_mode = 0;
    set_slots(32'h00_09_01_0B, 32'h0B_03_00_0A);
    run_frame(32, 0);
    run_frame(96, 0);
    run_frame(40, 0);
    delay_mode = 1;
    run_frame(96, 0);
    run_frame(32, 0);
    run_frame(96, 0);

    cur_req = "R6"; delay_mode = 0;
    set_slots(32'h06_04_02_00, 32'h06_04_02_00);
    repeat (3) run_frame(64, 2);
    delay_mode = 1;
    repeat (3) run_frame(64, 2);
    fsync = 1; tick();
    fsync = 0; tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule